// File: doc/BRIEF.md
# Alarm, Snooze and Radio Sleep Controller

This block sits beside a clock's time counter. It holds a settable alarm time, compares it with the running hours and minutes, and drives a tone enable with its square-wave tone and a radio control line. Once the alarm fires it runs for a bounded window of at most one hour. A snooze press silences the tone for seven minutes, and this can be repeated within that window. In radio-wake mode the alarm match switches the radio on for one hour instead of sounding the tone. A separate sleep timer keeps the radio on for one of eight binary-selected durations.

The alarm digits are set by holding set mode and pressing the hour or minute buttons while a 2 Hz advance pulse arrives. No carry passes between digits, and the time counter outside this block keeps running meanwhile. All timing is counted in pulses of a 1 Hz tick input. The parameters `SEC_PER_MIN`, `LIMIT_MIN`, `SNOOZE_MIN` and `SLEEP_STEP_MIN` scale every interval. The block has no streaming data path, so every pin is a plain level or a single-cycle pulse.

Top module: `alarm_sleep_ctl`

## Requirements
- R1: While `set_alarm` is high, each `adv_tick` pulse changes the alarm register with no carry between digits. With `adv_hour` alone, the hour steps through 0..23 and wraps to 0. With `adv_min` alone, the minute units step through 0..9 and wrap to 0. With both buttons, the minute tens step through 0..5 and wrap to 0.
- R2: While `set_alarm` is low, the alarm digits do not change, whatever the buttons and `adv_tick` do.
- R3: A clock edge at which the time equals the alarm time and `alarm_en` is high starts the alarm, and the outputs show it after that edge. While the time stays equal, the alarm starts at most once, even after it has ended or been cancelled. The time must differ for at least one edge before the alarm can start again.
- R4: Once started without radio wake, `tone_en` stays high for exactly `LIMIT_MIN*SEC_PER_MIN` pulses of `sec_tick`, including any snoozed time, and then falls.
- R5: `tone_out` is 0 at start. While `tone_en` is high, it toggles at every edge where `tone_rate` is high and holds at other edges. It is 0 from the edge after `tone_en` is sampled low.
- R6: A rising edge of `snooze_btn` while the tone sounds drops `tone_en` for `SNOOZE_MIN*SEC_PER_MIN` tick pulses, after which the tone resumes if the window is still open. Snooze presses while the tone is already silent are ignored. The snooze can be repeated without limit.
- R7: `alarm_en` low clears the running alarm window, any pending snooze and the radio-wake window.
- R8: With `wake_sel` high when the alarm starts, `radio_on` rises, stays high for `LIMIT_MIN*SEC_PER_MIN` tick pulses, and `tone_en` stays low.
- R9: A rising edge of `sleep_go` holds `radio_on` high for `(sleep_code+1)*SLEEP_STEP_MIN*SEC_PER_MIN` tick pulses, where bit 0 of `sleep_code` is the least significant bit. Holding `sleep_go` high does not restart the interval.
- R10: `radio_on` is high whenever the wake window or the sleep interval is running. A wake start at the same edge at which the sleep interval expires keeps `radio_on` high without a gap.
- R11: After reset, `tone_en`, `tone_out` and `radio_on` are 0 and the alarm time is 00:00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sec_tick | input | 1 | One-cycle pulse once per second |
| tone_rate | input | 1 | One-cycle pulse at twice the tone frequency |
| time_hour | input | 5 | Current hour, binary 0..23 |
| time_mtens | input | 3 | Current minute tens, 0..5 |
| time_munits | input | 4 | Current minute units, 0..9 |
| set_alarm | input | 1 | Alarm set mode |
| adv_tick | input | 1 | 2 Hz advance pulse |
| adv_hour | input | 1 | Hour advance button |
| adv_min | input | 1 | Minute advance button |
| alarm_en | input | 1 | Alarm enable switch |
| snooze_btn | input | 1 | Snooze button, debounced |
| wake_sel | input | 1 | Radio wake instead of tone |
| sleep_go | input | 1 | Sleep start switch |
| sleep_code | input | 3 | Sleep duration code |
| alarm_hour | output | 5 | Alarm hour |
| alarm_mtens | output | 3 | Alarm minute tens |
| alarm_munits | output | 4 | Alarm minute units |
| tone_en | output | 1 | Alarm tone enable |
| tone_out | output | 1 | Square-wave tone |
| radio_on | output | 1 | Radio wake/sleep control |

## Verification
Two pairs of functions can land on the same clock edge, and each pair is forced deliberately. In the first, a sleep interval is run down to its last tick, and the time is moved onto the alarm in exactly that tick cycle with radio wake selected. The bench then requires `radio_on` to stay high and to run a full wake window from that edge. In the second, the snooze button is pressed in the tick cycle that closes the alarm window. The bench requires the tone to stay off through a full snooze period, with no revived tone. Durations are judged by counting tick pulses against the arithmetic of R4, R6, R8 and R9.

// File: rtl/asc_pkg.sv
package asc_pkg;
  localparam int HOUR_W = 5;
  localparam int MT_W = 3;
  localparam int MU_W = 4;
  localparam int HOURS_PER_DAY = 24;
  localparam int MT_LAST = 5;
  localparam int MU_LAST = 9;

  typedef struct packed {
    logic [HOUR_W-1:0] hour;
    logic [MT_W-1:0]   mtens;
    logic [MU_W-1:0]   munits;
  } hhmm_t;

  localparam int TM_WIN = 0;
  localparam int TM_SNZ = 1;
  localparam int TM_WAKE = 2;
  localparam int TM_SLP = 3;
  localparam int N_TM = 4;
endpackage

// File: rtl/asc_alarm_reg.sv
module asc_alarm_reg
  import asc_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  set_mode,
  input  logic  adv_tick,
  input  logic  adv_hour,
  input  logic  adv_min,
  output hhmm_t alarm_o
);
  hhmm_t al_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      al_q <= '0;
    end else if (set_mode && adv_tick) begin
      if (adv_hour && adv_min) begin
        al_q.mtens <= (al_q.mtens == MT_W'(MT_LAST)) ? '0 : al_q.mtens + MT_W'(1);
      end else if (adv_hour) begin
        al_q.hour <= (al_q.hour == HOUR_W'(HOURS_PER_DAY - 1)) ? '0 : al_q.hour + HOUR_W'(1);
      end else if (adv_min) begin
        al_q.munits <= (al_q.munits == MU_W'(MU_LAST)) ? '0 : al_q.munits + MU_W'(1);
      end
    end
  end

  assign alarm_o = al_q;

  assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !set_mode |=> $stable(al_q));
  assert_digit_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (al_q.hour < HOUR_W'(HOURS_PER_DAY)) && (al_q.mtens <= MT_W'(MT_LAST)) &&
    (al_q.munits <= MU_W'(MU_LAST)));
endmodule

// File: rtl/asc_sec_timer.sv
module asc_sec_timer #(
  parameter int CNT_W = 13
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             clr,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             busy
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (clr) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= load_val;
    end else if (tick && cnt_q != '0) begin
      cnt_q <= cnt_q - CNT_W'(1);
    end
  end

  assign busy = (cnt_q != '0);

  assert_no_spont_start_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !load) |=> !busy);
  assert_load_starts_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (load && !clr && load_val != '0) |=> busy);
  assert_runs_on_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !tick && !clr) |=> busy);
endmodule

// File: rtl/asc_alarm_ctl.sv
module asc_alarm_ctl
  import asc_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  hhmm_t now_i,
  input  hhmm_t alarm_i,
  input  logic  alarm_en,
  input  logic  snooze_btn,
  input  logic  wake_sel,
  input  logic  win_busy,
  input  logic  snz_busy,
  input  logic  wake_busy,
  output logic  win_load,
  output logic  snz_load,
  output logic  wake_load,
  output logic  win_clr,
  output logic  snz_clr,
  output logic  wake_clr,
  output logic  tone_en
);
  logic same_min;
  logic fired_q;
  logic snz_q;
  logic start;

  assign same_min = (now_i == alarm_i);
  assign start = same_min && alarm_en && !fired_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fired_q <= 1'b0;
      snz_q <= 1'b0;
    end else begin
      snz_q <= snooze_btn;
      if (!same_min) fired_q <= 1'b0;
      else if (start) fired_q <= 1'b1;
    end
  end

  assign win_load = start && !wake_sel;
  assign wake_load = start && wake_sel;
  assign snz_load = snooze_btn && !snz_q && win_busy && !snz_busy;
  assign win_clr = !alarm_en;
  assign wake_clr = !alarm_en;
  assign snz_clr = !alarm_en || !win_busy;
  assign tone_en = win_busy && !snz_busy;

  assert_start_effect_R3: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (win_busy || wake_busy));
  assert_single_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> !start);
  assert_cancel_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !alarm_en |=> (!win_busy && !snz_busy && !wake_busy));
  assert_snooze_mutes_R6: assert property (@(posedge clk) disable iff (!rst_n)
    snz_load |=> !tone_en);
  assert_wake_silent_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wake_load |=> !tone_en);
endmodule

// File: rtl/asc_tone.sv
module asc_tone (
  input  logic clk,
  input  logic rst_n,
  input  logic tone_en,
  input  logic tone_rate,
  output logic tone_o
);
  logic sq_q;

  always_ff @(posedge clk) begin
    if (!rst_n) sq_q <= 1'b0;
    else if (!tone_en) sq_q <= 1'b0;
    else if (tone_rate) sq_q <= !sq_q;
  end

  assign tone_o = sq_q;

  assert_tone_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !tone_en |=> !tone_o);
  assert_tone_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (tone_en && !tone_rate) |=> $stable(tone_o));
endmodule

// File: rtl/alarm_sleep_ctl.sv
module alarm_sleep_ctl
  import asc_pkg::*;
#(
  parameter int SEC_PER_MIN = 60,
  parameter int LIMIT_MIN = 60,
  parameter int SNOOZE_MIN = 7,
  parameter int SLEEP_STEP_MIN = 15,
  parameter int SLEEP_CODE_W = 3
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    sec_tick,
  input  logic                    tone_rate,
  input  logic [HOUR_W-1:0]       time_hour,
  input  logic [MT_W-1:0]         time_mtens,
  input  logic [MU_W-1:0]         time_munits,
  input  logic                    set_alarm,
  input  logic                    adv_tick,
  input  logic                    adv_hour,
  input  logic                    adv_min,
  input  logic                    alarm_en,
  input  logic                    snooze_btn,
  input  logic                    wake_sel,
  input  logic                    sleep_go,
  input  logic [SLEEP_CODE_W-1:0] sleep_code,
  output logic [HOUR_W-1:0]       alarm_hour,
  output logic [MT_W-1:0]         alarm_mtens,
  output logic [MU_W-1:0]         alarm_munits,
  output logic                    tone_en,
  output logic                    tone_out,
  output logic                    radio_on
);
  localparam int WIN_TICKS = LIMIT_MIN * SEC_PER_MIN;
  localparam int SNZ_TICKS = SNOOZE_MIN * SEC_PER_MIN;
  localparam int SLP_MAX = (2 ** SLEEP_CODE_W) * SLEEP_STEP_MIN * SEC_PER_MIN;
  localparam int MAX_A = (WIN_TICKS > SNZ_TICKS) ? WIN_TICKS : SNZ_TICKS;
  localparam int MAX_TICKS = (MAX_A > SLP_MAX) ? MAX_A : SLP_MAX;
  localparam int CNT_W = $clog2(MAX_TICKS + 1);

  hhmm_t now_s, alarm_s;
  logic [N_TM-1:0] tm_load, tm_clr, tm_busy;
  logic [CNT_W-1:0] tm_val [N_TM];
  logic slp_q, slp_rise;

  assign now_s = '{hour: time_hour, mtens: time_mtens, munits: time_munits};

  asc_alarm_reg u_areg (
    .clk(clk), .rst_n(rst_n), .set_mode(set_alarm), .adv_tick(adv_tick),
    .adv_hour(adv_hour), .adv_min(adv_min), .alarm_o(alarm_s)
  );

  asc_alarm_ctl u_ctl (
    .clk(clk), .rst_n(rst_n), .now_i(now_s), .alarm_i(alarm_s),
    .alarm_en(alarm_en), .snooze_btn(snooze_btn), .wake_sel(wake_sel),
    .win_busy(tm_busy[TM_WIN]), .snz_busy(tm_busy[TM_SNZ]), .wake_busy(tm_busy[TM_WAKE]),
    .win_load(tm_load[TM_WIN]), .snz_load(tm_load[TM_SNZ]), .wake_load(tm_load[TM_WAKE]),
    .win_clr(tm_clr[TM_WIN]), .snz_clr(tm_clr[TM_SNZ]), .wake_clr(tm_clr[TM_WAKE]),
    .tone_en(tone_en)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) slp_q <= 1'b0;
    else slp_q <= sleep_go;
  end
  assign slp_rise = sleep_go && !slp_q;
  assign tm_load[TM_SLP] = slp_rise;
  assign tm_clr[TM_SLP] = 1'b0;

  always_comb begin
    tm_val[TM_WIN] = CNT_W'(WIN_TICKS);
    tm_val[TM_SNZ] = CNT_W'(SNZ_TICKS);
    tm_val[TM_WAKE] = CNT_W'(WIN_TICKS);
    tm_val[TM_SLP] = CNT_W'((int'(sleep_code) + 1) * SLEEP_STEP_MIN * SEC_PER_MIN);
  end

  for (genvar g = 0; g < N_TM; g++) begin : g_tm
    asc_sec_timer #(.CNT_W(CNT_W)) u_tm (
      .clk(clk), .rst_n(rst_n), .tick(sec_tick), .clr(tm_clr[g]),
      .load(tm_load[g]), .load_val(tm_val[g]), .busy(tm_busy[g])
    );
  end

  asc_tone u_tone (
    .clk(clk), .rst_n(rst_n), .tone_en(tone_en), .tone_rate(tone_rate), .tone_o(tone_out)
  );

  assign radio_on = tm_busy[TM_WAKE] || tm_busy[TM_SLP];
  assign alarm_hour = alarm_s.hour;
  assign alarm_mtens = alarm_s.mtens;
  assign alarm_munits = alarm_s.munits;

  assert_sleep_on_R9: assert property (@(posedge clk) disable iff (!rst_n)
    slp_rise |=> radio_on);
  assert_radio_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (radio_on && !sec_tick && alarm_en) |=> radio_on);
endmodule

// File: tb/alarm_sleep_ctl_tb_top.sv
module alarm_sleep_ctl_tb_top;
  localparam int CLK_P = 10;
  localparam int SPM = 2;
  localparam int LIM = 5;
  localparam int SNZ = 2;
  localparam int STEP = 1;
  localparam int WIN_T = LIM * SPM;
  localparam int SNZ_T = SNZ * SPM;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sec_tick = 0, tone_rate = 0, set_alarm = 0, adv_tick = 0, adv_hour = 0, adv_min = 0;
  logic alarm_en = 0, snooze_btn = 0, wake_sel = 0, sleep_go = 0;
  logic [4:0] time_hour = '0;
  logic [2:0] time_mtens = '0;
  logic [3:0] time_munits = '0;
  logic [2:0] sleep_code = '0;
  logic [4:0] alarm_hour;
  logic [2:0] alarm_mtens;
  logic [3:0] alarm_munits;
  logic tone_en, tone_out, radio_on;
  int total = 0;
  int bad = 0;
  bit done = 0;

  always #(CLK_P/2) clk = ~clk;

  alarm_sleep_ctl #(.SEC_PER_MIN(SPM), .LIMIT_MIN(LIM), .SNOOZE_MIN(SNZ),
                    .SLEEP_STEP_MIN(STEP), .SLEEP_CODE_W(3)) dut_i (
    .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick), .tone_rate(tone_rate),
    .time_hour(time_hour), .time_mtens(time_mtens), .time_munits(time_munits),
    .set_alarm(set_alarm), .adv_tick(adv_tick), .adv_hour(adv_hour), .adv_min(adv_min),
    .alarm_en(alarm_en), .snooze_btn(snooze_btn), .wake_sel(wake_sel),
    .sleep_go(sleep_go), .sleep_code(sleep_code),
    .alarm_hour(alarm_hour), .alarm_mtens(alarm_mtens), .alarm_munits(alarm_munits),
    .tone_en(tone_en), .tone_out(tone_out), .radio_on(radio_on)
  );

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(input bit st);
    sec_tick = st;
    @(posedge clk);
    #1;
    sec_tick = 0;
  endtask

  task automatic adv_once();
    adv_tick = 1;
    cyc(0);
    adv_tick = 0;
  endtask

  task automatic set_time(input int h, input int mt, input int mu);
    time_hour = 5'(h);
    time_mtens = 3'(mt);
    time_munits = 4'(mu);
    cyc(0);
  endtask

  task automatic count_tone(output int n);
    n = 0;
    while (tone_en && n < 500) begin cyc(1); n++; end
  endtask

  task automatic count_radio(output int n);
    n = 0;
    while (radio_on && n < 500) begin cyc(1); n++; end
  endtask

  task automatic count_silent(output int n);
    n = 0;
    while (!tone_en && n < 500) begin cyc(1); n++; end
  endtask

  task automatic restart();
    set_time(6, 2, 4);
    set_time(6, 2, 3);
  endtask

  initial begin
    #(CLK_P * 100000);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int n;
    repeat (3) @(posedge clk);
    #1;
    rst_n = 1;
    cyc(0);
    // R11 reset state
    chk("R11 tone_en", int'(tone_en), 0);
    chk("R11 tone_out", int'(tone_out), 0);
    chk("R11 radio_on", int'(radio_on), 0);
    chk("R11 alarm", int'({alarm_hour, alarm_mtens, alarm_munits}), 0);

    // R1 exhaustive digit sweeps
    set_alarm = 1;
    adv_hour = 1;
    for (int k = 1; k <= 30; k++) begin
      adv_once();
      chk("R1 hour", int'(alarm_hour), k % 24);
      chk("R1 hour no carry", int'(alarm_mtens) * 10 + int'(alarm_munits), 0);
    end
    adv_hour = 0;
    adv_min = 1;
    for (int k = 1; k <= 13; k++) begin
      adv_once();
      chk("R1 units", int'(alarm_munits), k % 10);
      chk("R1 units no carry", int'(alarm_mtens) + 100 * int'(alarm_hour), 600);
    end
    adv_hour = 1;
    for (int k = 1; k <= 8; k++) begin
      adv_once();
      chk("R1 tens", int'(alarm_mtens), k % 6);
      chk("R1 tens no carry", int'(alarm_munits) + 100 * int'(alarm_hour), 603);
    end
    // R2 no change outside set mode
    set_alarm = 0;
    for (int k = 0; k < 5; k++) begin
      adv_hour = k[0];
      adv_min = 1;
      adv_once();
      chk("R2 hold", int'({alarm_hour, alarm_mtens, alarm_munits}), int'({5'd6, 3'd2, 4'd3}));
    end
    adv_hour = 0;
    adv_min = 0;

    // R3 start on match, R5 tone, R4 window
    set_time(6, 2, 2);
    alarm_en = 1;
    cyc(0);
    chk("R3 no match", int'(tone_en), 0);
    set_time(6, 2, 3);
    chk("R3 start", int'(tone_en), 1);
    chk("R5 start low", int'(tone_out), 0);
    tone_rate = 1;
    for (int k = 1; k <= 4; k++) begin
      cyc(0);
      chk("R5 toggle", int'(tone_out), k % 2);
    end
    tone_rate = 0;
    cyc(0);
    chk("R5 hold", int'(tone_out), 0);
    count_tone(n);
    chk("R4 window", n, WIN_T);
    tone_rate = 1;
    for (int k = 0; k < 3; k++) begin
      cyc(1);
      chk("R3 no retrigger", int'(tone_en), 0);
      chk("R5 quiet", int'(tone_out), 0);
    end
    tone_rate = 0;
    restart();
    chk("R3 rearm", int'(tone_en), 1);

    // R6 snooze, repeat, ignored press while silent
    cyc(1);
    snooze_btn = 1;
    cyc(0);
    chk("R6 mute", int'(tone_en), 0);
    cyc(1);
    cyc(1);
    snooze_btn = 0;
    cyc(0);
    snooze_btn = 1;
    cyc(0);
    snooze_btn = 0;
    count_silent(n);
    chk("R6 resume", n, SNZ_T - 2);
    snooze_btn = 1;
    cyc(0);
    snooze_btn = 0;
    chk("R6 repeat mute", int'(tone_en), 0);
    count_silent(n);
    chk("R6 repeat resume", n, SNZ_T);
    count_tone(n);
    chk("R4 window incl snooze", n, WIN_T - 1 - 2 * SNZ_T);

    // R7 cancel clears alarm and pending snooze
    restart();
    snooze_btn = 1;
    cyc(0);
    snooze_btn = 0;
    alarm_en = 0;
    cyc(0);
    chk("R7 cancel", int'(tone_en), 0);
    alarm_en = 1;
    for (int k = 0; k < SNZ_T + 2; k++) begin
      cyc(1);
      chk("R7 snooze cleared", int'(tone_en), 0);
    end

    // R8 radio wake
    wake_sel = 1;
    restart();
    chk("R8 radio", int'(radio_on), 1);
    chk("R8 no tone", int'(tone_en), 0);
    count_radio(n);
    chk("R8 wake window", n, WIN_T);
    restart();
    alarm_en = 0;
    cyc(0);
    chk("R7 wake cancel", int'(radio_on), 0);
    alarm_en = 1;

    // R9 sleep sweep over all codes
    set_time(6, 2, 4);
    for (int c = 0; c < 8; c++) begin
      sleep_code = 3'(c);
      sleep_go = 1;
      cyc(0);
      sleep_go = 0;
      chk("R9 sleep on", int'(radio_on), 1);
      count_radio(n);
      chk("R9 sleep length", n, (c + 1) * STEP * SPM);
    end
    sleep_code = 3'd0;
    sleep_go = 1;
    cyc(0);
    count_radio(n);
    chk("R9 level no restart", n, STEP * SPM);
    sleep_go = 0;
    cyc(0);

    // R10 wake start on the sleep expiry edge
    sleep_go = 1;
    cyc(0);
    sleep_go = 0;
    cyc(1);
    time_munits = 4'd3;
    cyc(1);
    chk("R10 no gap", int'(radio_on), 1);
    count_radio(n);
    chk("R10 wake after sleep", n, WIN_T);

    // snooze on the window-closing edge
    wake_sel = 0;
    restart();
    for (int k = 0; k < WIN_T - 1; k++) cyc(1);
    chk("R4 last tick", int'(tone_en), 1);
    snooze_btn = 1;
    cyc(1);
    snooze_btn = 0;
    chk("R6 end with snooze", int'(tone_en), 0);
    for (int k = 0; k < SNZ_T + 1; k++) begin
      cyc(1);
      chk("R6 no revive", int'(tone_en), 0);
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule